// File: doc/BRIEF.md
# E1 Basic Frame Aligner

This block locks onto the 256-bit frame structure of a 2.048 Mb/s E1 receive stream. It takes one bit at a time with a valid strobe. It slides a 7-bit window over the stream, looking for the alignment word. Before it declares lock, it runs a three-step qualification. First a candidate alignment word is found. Then the second bit of timeslot 0 in the following frame must be a one. Finally the alignment word must appear again at the same position two frames after the candidate.

While locked, it publishes the position of the most recently accepted bit as a timeslot count and a bit-in-timeslot count, together with a flag that marks the frames carrying the alignment word. It keeps checking the alignment word in every alignment frame. Three misses in a row send it back to hunting. Bits are taken MSB first. Frame bit index 0 is the first bit of timeslot 0, and the alignment word 0011011 sits at frame bit indices 1 to 7.

Top module: `e1fa_framer`

## Requirements
- R1: After synchronous reset, sync_n is 1, ts_cnt and bit_cnt are 0 and fas_frm is 0.
- R2: While hunting, any accepted bit that completes the window 0011011 (oldest bit first) makes it a candidate. One clock later ts_cnt=0, bit_cnt=7 and fas_frm=1, and sync_n stays 1.
- R3: After a candidate, if the bit at frame index 1 of the next frame (the second bit of timeslot 0) is 0, the candidate is dropped. Hunting resumes with the very next accepted bit, so an alignment word arriving two frames after the dropped candidate only starts a new candidate.
- R4: If that bit is 1 and the bits at frame indices 1 to 7 of the frame after it equal 0011011, sync_n goes to 0 one clock after the seventh of those bits is accepted, with ts_cnt=0, bit_cnt=7, fas_frm=1.
- R5: If that confirming alignment word is wrong, the framer returns to hunting and sync_n stays 1.
- R6: Each accepted bit advances the frame position {ts_cnt, bit_cnt} by one, wrapping from 255 to 0. ts_cnt is position/8 and bit_cnt is position mod 8.
- R7: A clock edge with rx_vld=0 changes no output and no internal state.
- R8: fas_frm inverts each time the position wraps from 255 to 0, so alignment frames and non-alignment frames alternate.
- R9: In sync, three consecutive alignment frames whose indices 1 to 7 are not 0011011 set sync_n to 1 one clock after the third, with the position at 7. A correct alignment word clears the miss count.
- R10: In sync, non-alignment frame contents and all bits outside timeslot 0 are never checked. An alignment-like pattern there leaves sync and the position unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_bit | input | 1 | Received serial bit |
| rx_vld | input | 1 | rx_bit is accepted at this edge |
| sync_n | output | 1 | Low while basic frame alignment holds |
| ts_cnt | output | 5 | Timeslot of the last accepted bit |
| bit_cnt | output | 3 | Bit within timeslot of the last accepted bit |
| fas_frm | output | 1 | High during frames that carry the alignment word |

## Verification
Every result here is due exactly one clock after the valid edge that accepts the deciding bit: the candidate load, the rejection, the lock, the miss count, the loss, and each position step. Nothing in the path is pipelined further. The bench drives each bit just after an edge, lets the next rising edge consume it, drops the strobe, and samples the outputs one time unit after that edge. Each check therefore reads the state produced by the bit just sent. Hold-off checks idle the strobe for several edges and compare the outputs taken before and after the idle period.

// File: rtl/e1fa_pkg.sv
package e1fa_pkg;
  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_NFAS = 2'd1,
    ST_CONF = 2'd2,
    ST_SYNC = 2'd3
  } fa_state_t;

  localparam int FAW_BITS = 7;
  localparam logic [FAW_BITS-1:0] FAW_PATTERN = 7'b0011011;
endpackage

// File: rtl/e1fa_window.sv
module e1fa_window #(
  parameter int PW = 7,
  parameter logic [PW-1:0] PAT = 7'b0011011
) (
  input  logic clk,
  input  logic rst,
  input  logic vld,
  input  logic din,
  output logic match
);
  logic [PW-2:0] hist;
  logic [PW-1:0] win;

  assign win   = {hist, din};
  assign match = (win == PAT);

  always_ff @(posedge clk) begin
    if (rst) hist <= '1;
    else if (vld) hist <= win[PW-2:0];
  end
endmodule

// File: rtl/e1fa_position.sv
module e1fa_position #(
  parameter int FRAME_BITS = 256,
  parameter int FAS_END = 7,
  localparam int PSW = $clog2(FRAME_BITS)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           vld,
  input  logic           load,
  output logic [PSW-1:0] pos,
  output logic [PSW-1:0] nxt,
  output logic           fas
);
  assign nxt = (pos == PSW'(FRAME_BITS - 1)) ? '0 : pos + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos <= '0;
      fas <= 1'b0;
    end else if (vld) begin
      if (load) begin
        pos <= PSW'(FAS_END);
        fas <= 1'b1;
      end else begin
        pos <= nxt;
        if (nxt == '0) fas <= ~fas;
      end
    end
  end
endmodule

// File: rtl/e1fa_ctrl.sv
module e1fa_ctrl
  import e1fa_pkg::*;
#(
  parameter int PSW = 8,
  parameter int FAS_END = 7,
  parameter int NFAS_BIT = 1,
  parameter int LOSS_LIMIT = 3,
  localparam int MW = $clog2(LOSS_LIMIT + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           vld,
  input  logic           din,
  input  logic           match,
  input  logic [PSW-1:0] nxt,
  input  logic           fas,
  output logic           load,
  output logic           sync_n
);
  fa_state_t      st;
  logic [MW-1:0]  miss;
  logic           at_fas;
  logic           at_nfas;

  assign at_fas  = (nxt == PSW'(FAS_END)) && fas;
  assign at_nfas = (nxt == PSW'(NFAS_BIT)) && !fas;
  assign load    = vld && (st == ST_HUNT) && match;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_HUNT;
      miss   <= '0;
      sync_n <= 1'b1;
    end else if (vld) begin
      case (st)
        ST_HUNT: if (match) st <= ST_NFAS;
        ST_NFAS: if (at_nfas) st <= din ? ST_CONF : ST_HUNT;
        ST_CONF: begin
          if (at_fas) begin
            if (match) begin
              st     <= ST_SYNC;
              sync_n <= 1'b0;
              miss   <= '0;
            end else begin
              st <= ST_HUNT;
            end
          end
        end
        default: begin
          if (at_fas) begin
            if (match) begin
              miss <= '0;
            end else if (miss == MW'(LOSS_LIMIT - 1)) begin
              st     <= ST_HUNT;
              sync_n <= 1'b1;
              miss   <= '0;
            end else begin
              miss <= miss + 1'b1;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/e1fa_framer.sv
module e1fa_framer
  import e1fa_pkg::*;
#(
  parameter int FRAME_BITS = 256,
  parameter int LOSS_LIMIT = 3,
  localparam int PSW = $clog2(FRAME_BITS)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           rx_bit,
  input  logic           rx_vld,
  output logic           sync_n,
  output logic [PSW-4:0] ts_cnt,
  output logic [2:0]     bit_cnt,
  output logic           fas_frm
);
  localparam int FAS_END  = FAW_BITS;
  localparam int NFAS_BIT = 1;

  logic           match;
  logic           load;
  logic [PSW-1:0] pos;
  logic [PSW-1:0] nxt;
  logic           fas;

  e1fa_window #(.PW(FAW_BITS), .PAT(FAW_PATTERN)) u_win (
    .clk(clk), .rst(rst), .vld(rx_vld), .din(rx_bit), .match(match)
  );

  e1fa_position #(.FRAME_BITS(FRAME_BITS), .FAS_END(FAS_END)) u_pos (
    .clk(clk), .rst(rst), .vld(rx_vld), .load(load),
    .pos(pos), .nxt(nxt), .fas(fas)
  );

  e1fa_ctrl #(
    .PSW(PSW), .FAS_END(FAS_END), .NFAS_BIT(NFAS_BIT), .LOSS_LIMIT(LOSS_LIMIT)
  ) u_ctrl (
    .clk(clk), .rst(rst), .vld(rx_vld), .din(rx_bit), .match(match),
    .nxt(nxt), .fas(fas), .load(load), .sync_n(sync_n)
  );

  assign ts_cnt  = pos[PSW-1:3];
  assign bit_cnt = pos[2:0];
  assign fas_frm = fas;
endmodule

// File: rtl/e1fa_framer_chk.sv
module e1fa_framer_chk #(
  parameter int FRAME_BITS = 256,
  parameter int FAS_END = 7,
  localparam int PSW = $clog2(FRAME_BITS)
) (
  input logic           clk,
  input logic           rst,
  input logic           rx_vld,
  input logic           sync_n,
  input logic [PSW-4:0] ts_cnt,
  input logic [2:0]     bit_cnt,
  input logic           fas_frm
);
  logic [PSW-1:0] posv;
  assign posv = {ts_cnt, bit_cnt};

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (sync_n && posv == '0 && !fas_frm));

  a_r4_lock_at_fas: assert property (@(posedge clk) disable iff (rst)
    $fell(sync_n) |-> (posv == PSW'(FAS_END) && fas_frm));

  a_r9_loss_at_fas: assert property (@(posedge clk) disable iff (rst)
    ($rose(sync_n) && !$past(rst)) |-> (posv == PSW'(FAS_END) && fas_frm));

  a_r6_step: assert property (@(posedge clk) disable iff (rst)
    (rx_vld && !sync_n) |=>
      (posv == (($past(posv) == PSW'(FRAME_BITS - 1)) ? '0 : $past(posv) + 1'b1)));

  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !rx_vld |=> ($stable(posv) && $stable(sync_n) && $stable(fas_frm)));

  a_r8_flip: assert property (@(posedge clk) disable iff (rst)
    (rx_vld && !sync_n && posv == PSW'(FRAME_BITS - 1)) |=> (fas_frm != $past(fas_frm)));
endmodule

bind e1fa_framer e1fa_framer_chk #(.FRAME_BITS(FRAME_BITS), .FAS_END(FAS_END)) u_chk (
  .clk(clk), .rst(rst), .rx_vld(rx_vld), .sync_n(sync_n),
  .ts_cnt(ts_cnt), .bit_cnt(bit_cnt), .fas_frm(fas_frm)
);

// File: tb/e1fa_framer_test.sv
module e1fa_framer_test;
  localparam int CLK_P = 10;
  localparam logic [7:0] TS0_FAS  = 8'h9B;
  localparam logic [7:0] TS0_NFAS = 8'hFF;
  localparam logic [7:0] TS0_BADN = 8'hBF;
  localparam logic [7:0] TS0_BADF = 8'hFF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_bit = 1'b1;
  logic rx_vld = 1'b0;
  logic sync_n;
  logic [4:0] ts_cnt;
  logic [2:0] bit_cnt;
  logic fas_frm;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  e1fa_framer uut (
    .clk(clk), .rst(rst), .rx_bit(rx_bit), .rx_vld(rx_vld),
    .sync_n(sync_n), .ts_cnt(ts_cnt), .bit_cnt(bit_cnt), .fas_frm(fas_frm)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_pos(input string req, input int ts, input int bc, input int f, input int s);
    check({req, " ts_cnt"}, ts_cnt, ts);
    check({req, " bit_cnt"}, bit_cnt, bc);
    check({req, " fas_frm"}, fas_frm, f);
    check({req, " sync_n"}, sync_n, s);
  endtask

  task automatic send_bit(input logic b);
    rx_bit = b;
    rx_vld = 1'b1;
    @(posedge clk);
    #1;
    rx_vld = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic send_ones(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b1);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    rx_vld = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
  endtask

  task automatic acquire(input int lead);
    send_ones(lead);
    send_byte(TS0_FAS);
    send_ones(248);
    send_byte(TS0_NFAS);
    send_ones(248);
    send_byte(TS0_FAS);
  endtask

  task automatic t_reset();
    do_reset();
    check_pos("R1 reset", 0, 0, 0, 1);
  endtask

  task automatic t_acquire();
    do_reset();
    send_ones(37);
    send_byte(TS0_FAS);
    check_pos("R2 candidate", 0, 7, 1, 1);
    send_ones(248);
    send_byte(TS0_NFAS);
    check_pos("R4 nfas frame", 0, 7, 0, 1);
    send_ones(248);
    send_byte(TS0_FAS);
    check_pos("R4 lock", 0, 7, 1, 0);
  endtask

  task automatic t_counting();
    logic [9:0] snap;
    send_ones(32);
    check_pos("R6 step", 4, 7, 1, 0);
    send_byte(TS0_FAS);
    check_pos("R10 payload word", 5, 7, 1, 0);
    send_ones(208);
    check_pos("R6 end of frame", 31, 7, 1, 0);
    send_bit(1'b1);
    check_pos("R8 wrap", 0, 0, 0, 0);
    send_ones(7);
    snap = {sync_n, ts_cnt, bit_cnt, fas_frm};
    rx_bit = 1'b0;
    repeat (5) @(posedge clk);
    #1;
    check("R7 idle hold", {sync_n, ts_cnt, bit_cnt, fas_frm}, snap);
    send_bit(1'b1);
    check_pos("R7 resume", 1, 0, 0, 0);
  endtask

  task automatic t_reject();
    do_reset();
    send_ones(20);
    send_byte(TS0_FAS);
    send_ones(248);
    send_byte(TS0_BADN);
    send_ones(248);
    send_byte(TS0_FAS);
    check_pos("R3 rejected no lock", 0, 7, 1, 1);
    send_ones(248);
    send_byte(TS0_NFAS);
    send_ones(248);
    send_byte(TS0_FAS);
    check_pos("R3 relock", 0, 7, 1, 0);
  endtask

  task automatic t_confirm_fail();
    do_reset();
    send_ones(5);
    send_byte(TS0_FAS);
    send_ones(248);
    send_byte(TS0_NFAS);
    send_ones(248);
    send_byte(TS0_BADF);
    check("R5 confirm miss", sync_n, 1);
    send_ones(248);
    send_byte(TS0_FAS);
    check_pos("R5 new candidate", 0, 7, 1, 1);
    send_ones(248);
    send_byte(TS0_NFAS);
    send_ones(248);
    send_byte(TS0_FAS);
    check("R5 later lock", sync_n, 0);
  endtask

  task automatic next_fas(input logic [7:0] nfas_ts0, input logic [7:0] fas_ts0);
    send_ones(248);
    send_byte(nfas_ts0);
    send_ones(248);
    send_byte(fas_ts0);
  endtask

  task automatic t_loss();
    do_reset();
    acquire(11);
    check("R9 locked", sync_n, 0);
    next_fas(TS0_NFAS, TS0_BADF);
    check("R9 miss1", sync_n, 0);
    next_fas(TS0_BADN, TS0_BADF);
    check("R10 nfas ignored", sync_n, 0);
    next_fas(TS0_NFAS, TS0_FAS);
    check("R9 good clears", sync_n, 0);
    next_fas(TS0_NFAS, TS0_BADF);
    next_fas(TS0_NFAS, TS0_BADF);
    check("R9 two misses", sync_n, 0);
    next_fas(TS0_NFAS, TS0_BADF);
    check_pos("R9 lost", 0, 7, 1, 1);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_acquire();
    t_counting();
    t_reject();
    t_confirm_fail();
    t_loss();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule